// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the fetch stage for a byte-oriented instruction encoding in which one instruction occupies between 1 and 10 bytes. It holds the program counter in a register. Each cycle it takes a 10-byte window of instruction memory that begins at that counter. It splits the leading byte into a class code and a function code, pulls out the register-specifier pair and the 64-bit constant when the class carries them, and works out the instruction length and the sequential next PC.

The class code alone decides the format. It sets whether a register byte follows the leading byte and whether an 8-byte constant follows after that. The length and the position of the constant both come from these two choices. Class codes above 0xB are reported as invalid, and an invalid instruction never moves the PC. When the advance enable is high and the instruction is valid, the PC takes the next-PC value on the rising clock edge.

Window byte k, meaning the byte at address PC+k, sits on bits [8k+7:8k] of `win_i`.

Top module: `varlen_fetch`

## Requirements
- R1: While `rst_ni` is low, `pc_o` is held at zero.
- R2: `cls_o` is bits [7:4] of window byte 0 and `fn_o` is bits [3:0] of window byte 0.
- R3: For a valid class, `len_o` is 1 for classes 0x0, 0x1 and 0x9. It is 2 for classes 0x2, 0x6, 0xA and 0xB. It is 9 for classes 0x7 and 0x8. It is 10 for classes 0x3, 0x4 and 0x5.
- R4: For classes that carry a register byte (0x2 to 0x6, 0xA, 0xB), `ra_o` is bits [7:4] of window byte 1 and `rb_o` is bits [3:0] of window byte 1. For every other valid class, both outputs read 0xF.
- R5: For classes 0x7 and 0x8, `imm_o` is window bytes 1 to 8 assembled little-endian, so byte 1 lands on bits [7:0]. For classes 0x3 to 0x5 it is window bytes 2 to 9 assembled the same way. For every other valid class, `imm_o` is zero.
- R6: `next_pc_o` equals `pc_o + len_o`, taken modulo 2^64.
- R7: `bad_o` is high exactly when the class code is greater than 0xB.
- R8: On a rising clock edge with `adv_en_i` high and `bad_o` low, `pc_o` takes the `next_pc_o` value that was present before the edge. When `adv_en_i` is low, `pc_o` is unchanged.
- R9: When `bad_o` is high, `pc_o` is unchanged on a rising clock edge, even with `adv_en_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_en_i | input | 1 | Allows the PC to advance |
| win_i | input | 80 | Instruction bytes at PC..PC+9, byte k on [8k+7:8k] |
| pc_o | output | 64 | Current program counter |
| cls_o | output | 4 | Instruction class code |
| fn_o | output | 4 | Function code |
| ra_o | output | 4 | First register field, 0xF when absent |
| rb_o | output | 4 | Second register field, 0xF when absent |
| imm_o | output | 64 | Constant word, zero when absent |
| len_o | output | 4 | Decoded instruction length in bytes |
| next_pc_o | output | 64 | Sequential next PC |
| bad_o | output | 1 | Invalid class code |

## Verification
The assertions run on every cycle. They keep the decoded length within the four legal sizes, and they check that classes without a register byte or constant present the empty values. They also check the PC transfer rule: a step to the prior next-PC when enabled and valid, and no change when the enable is low or the code is invalid. What the assertions cannot show is the arithmetic correctness of each field: the exact class-to-length mapping, which window bytes feed the constant and in what order, and the nibble split. These come from the bench's sweep over every leading-byte value and its walk through all valid classes with the advance enable high.

// File: rtl/varlen_pkg.sv
package varlen_pkg;
  localparam int unsigned NIB_W = 4;
  localparam logic [NIB_W-1:0] REG_NONE = 4'hF;
  localparam logic [NIB_W-1:0] CLS_MAX = 4'hB;

  typedef enum logic [NIB_W-1:0] {
    CL_HALT  = 4'h0,
    CL_NOP   = 4'h1,
    CL_MOVR  = 4'h2,
    CL_MOVI  = 4'h3,
    CL_STORE = 4'h4,
    CL_LOAD  = 4'h5,
    CL_ALU   = 4'h6,
    CL_JUMP  = 4'h7,
    CL_CALL  = 4'h8,
    CL_RET   = 4'h9,
    CL_PUSH  = 4'hA,
    CL_POP   = 4'hB
  } cls_e;

  typedef struct packed {
    logic has_reg;
    logic has_imm;
    logic bad;
  } fmt_t;
endpackage

// File: rtl/varlen_fmt.sv
module varlen_fmt
  import varlen_pkg::*;
#(
  parameter int unsigned IMM_BYTES = 8,
  localparam int unsigned LEN_W = $clog2(IMM_BYTES + 3)
) (
  input  logic [NIB_W-1:0] cls_i,
  output fmt_t             fmt_o,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    fmt_o = '{has_reg: 1'b0, has_imm: 1'b0, bad: 1'b0};
    case (cls_i)
      CL_HALT, CL_NOP, CL_RET: ;
      CL_MOVR, CL_ALU, CL_PUSH, CL_POP: fmt_o.has_reg = 1'b1;
      CL_JUMP, CL_CALL: fmt_o.has_imm = 1'b1;
      CL_MOVI, CL_STORE, CL_LOAD: begin
        fmt_o.has_reg = 1'b1;
        fmt_o.has_imm = 1'b1;
      end
      default: fmt_o.bad = 1'b1;
    endcase
  end

  // one opcode byte, optional register byte, optional constant
  always_comb begin
    len_o = LEN_W'(1);
    if (fmt_o.has_reg) len_o = len_o + LEN_W'(1);
    if (fmt_o.has_imm) len_o = len_o + LEN_W'(IMM_BYTES);
  end
endmodule

// File: rtl/varlen_fields.sv
module varlen_fields
  import varlen_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 10,
  parameter int unsigned IMM_BYTES = 8,
  localparam int unsigned WIN_W = WIN_BYTES * 8,
  localparam int unsigned IMM_W = IMM_BYTES * 8
) (
  input  logic [WIN_W-1:0] win_i,
  input  fmt_t             fmt_i,
  output logic [NIB_W-1:0] ra_o,
  output logic [NIB_W-1:0] rb_o,
  output logic [IMM_W-1:0] imm_o
);
  logic [7:0] reg_byte;
  assign reg_byte = win_i[15:8];

  assign ra_o = fmt_i.has_reg ? reg_byte[7:4] : REG_NONE;
  assign rb_o = fmt_i.has_reg ? reg_byte[3:0] : REG_NONE;

  // constant starts after the register byte if one is present
  for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm
    logic [7:0] b_near, b_far;
    assign b_near = win_i[(1 + k)*8 +: 8];
    assign b_far  = win_i[(2 + k)*8 +: 8];
    assign imm_o[k*8 +: 8] = !fmt_i.has_imm ? 8'h00 :
                             fmt_i.has_reg  ? b_far : b_near;
  end
endmodule

// File: rtl/varlen_pc.sv
module varlen_pc #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_en_i,
  input  logic             bad_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  next_pc_o
);
  logic [PC_W-1:0] pc_q;

  assign next_pc_o = pc_q + PC_W'(len_i);
  assign pc_o      = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (adv_en_i && !bad_i) pc_q <= next_pc_o;
  end
endmodule

// File: rtl/varlen_fetch.sv
module varlen_fetch
  import varlen_pkg::*;
#(
  parameter int unsigned PC_W      = 64,
  parameter int unsigned IMM_BYTES = 8,
  localparam int unsigned WIN_BYTES = IMM_BYTES + 2,
  localparam int unsigned WIN_W     = WIN_BYTES * 8,
  localparam int unsigned IMM_W     = IMM_BYTES * 8,
  localparam int unsigned LEN_W     = $clog2(WIN_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_en_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [3:0]       cls_o,
  output logic [3:0]       fn_o,
  output logic [3:0]       ra_o,
  output logic [3:0]       rb_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [LEN_W-1:0] len_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             bad_o
);
  fmt_t fmt;

  assign cls_o = win_i[7:4];
  assign fn_o  = win_i[3:0];
  assign bad_o = fmt.bad;

  varlen_fmt #(.IMM_BYTES(IMM_BYTES)) u_fmt (
    .cls_i (cls_o),
    .fmt_o (fmt),
    .len_o (len_o)
  );

  varlen_fields #(.WIN_BYTES(WIN_BYTES), .IMM_BYTES(IMM_BYTES)) u_fields (
    .win_i (win_i),
    .fmt_i (fmt),
    .ra_o  (ra_o),
    .rb_o  (rb_o),
    .imm_o (imm_o)
  );

  varlen_pc #(.PC_W(PC_W), .LEN_W(LEN_W)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_en_i  (adv_en_i),
    .bad_i     (fmt.bad),
    .len_i     (len_o),
    .pc_o      (pc_o),
    .next_pc_o (next_pc_o)
  );
endmodule

// File: rtl/varlen_fetch_chk.sv
module varlen_fetch_chk #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned IMM_W = 64,
  parameter int unsigned LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adv_en_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [3:0]       ra_o,
  input logic [3:0]       rb_o,
  input logic [IMM_W-1:0] imm_o,
  input logic [LEN_W-1:0] len_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             bad_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_len_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_o |-> (len_o == 1 || len_o == 2 || len_o == 9 || len_o == 10));

  p_no_reg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bad_o && (len_o == 1 || len_o == 9)) |-> (ra_o == 4'hF && rb_o == 4'hF));

  p_no_imm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bad_o && len_o < 9) |-> imm_o == '0);

  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(adv_en_i && !bad_o)) |-> pc_o == $past(next_pc_o));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(adv_en_i)) |-> $stable(pc_o));

  p_bad_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(bad_o)) |-> $stable(pc_o));
endmodule

bind varlen_fetch varlen_fetch_chk #(.PC_W(PC_W), .IMM_W(IMM_W), .LEN_W(LEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .adv_en_i  (adv_en_i),
  .pc_o      (pc_o),
  .ra_o      (ra_o),
  .rb_o      (rb_o),
  .imm_o     (imm_o),
  .len_o     (len_o),
  .next_pc_o (next_pc_o),
  .bad_o     (bad_o)
);

// File: tb/varlen_fetch_tb.sv
module varlen_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        adv_en = 1'b0;
  logic [79:0] win = '0;
  logic [63:0] pc, next_pc, imm;
  logic [3:0]  cls, fn, ra, rb, len;
  logic        bad;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  varlen_fetch u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .adv_en_i(adv_en), .win_i(win),
    .pc_o(pc), .cls_o(cls), .fn_o(fn), .ra_o(ra), .rb_o(rb),
    .imm_o(imm), .len_o(len), .next_pc_o(next_pc), .bad_o(bad)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int c);
    case (c)
      0, 1, 9:        return 1;
      2, 6, 10, 11:   return 2;
      7, 8:           return 9;
      3, 4, 5:        return 10;
      default:        return 0;
    endcase
  endfunction

  function automatic logic [79:0] mk_win(input int c, input int f, input int seed);
    logic [79:0] w;
    for (int i = 1; i < 10; i++) w[i*8 +: 8] = 8'((c*37 + f*11 + i*53 + seed*29 + 7) & 255);
    w[7:0] = {4'(c), 4'(f)};
    return w;
  endfunction

  task automatic check_comb(input logic [79:0] w);
    int c, l, off;
    logic [63:0] e_imm;
    c = int'(w[7:4]);
    l = exp_len(c);
    chk("R2 cls", 64'(cls), 64'(w[7:4]));
    chk("R2 fn", 64'(fn), 64'(w[3:0]));
    chk("R7 bad", 64'(bad), 64'(c > 11));
    if (c <= 11) begin
      chk("R3 len", 64'(len), 64'(l));
      if (l == 2 || l == 10) begin
        chk("R4 ra", 64'(ra), 64'(w[15:12]));
        chk("R4 rb", 64'(rb), 64'(w[11:8]));
      end else begin
        chk("R4 ra none", 64'(ra), 64'hF);
        chk("R4 rb none", 64'(rb), 64'hF);
      end
      e_imm = '0;
      if (l >= 9) begin
        off = (l == 9) ? 1 : 2;
        for (int k = 0; k < 8; k++) e_imm[k*8 +: 8] = w[(off+k)*8 +: 8];
      end
      chk("R5 imm", imm, e_imm);
      chk("R6 next_pc", next_pc, pc + 64'(l));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] exp_pc;
    #23;
    chk("R1 reset pc", pc, 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc, 64'h0);

    // sweep every leading byte, advance off
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        win = mk_win(c, f, 0);
        #1;
        check_comb(win);
        @(negedge clk);
        chk("R8 hold without enable", pc, 64'h0);
      end
    end

    // step through all valid classes with advance on
    exp_pc = 64'h0;
    adv_en = 1'b1;
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 12; c++) begin
        win = mk_win(c, r + 3, r + 1);
        #1;
        check_comb(win);
        exp_pc = exp_pc + 64'(exp_len(c));
        @(posedge clk);
        #1;
        chk("R8 pc advance", pc, exp_pc);
        @(negedge clk);
      end
    end

    // invalid codes with advance on: no movement
    for (int c = 12; c < 16; c++) begin
      win = mk_win(c, 5, 2);
      #1;
      chk("R7 bad set", 64'(bad), 64'h1);
      @(posedge clk);
      #1;
      chk("R9 invalid holds pc", pc, exp_pc);
      @(negedge clk);
    end

    // valid code, enable dropped
    adv_en = 1'b0;
    win = mk_win(3, 1, 4);
    repeat (2) @(posedge clk);
    #1;
    chk("R8 enable low holds", pc, exp_pc);

    // asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", pc, 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule